// File: doc/BRIEF.md
# PCI Initiator Transaction Sequencer

This block plays the initiator role for one transaction at a time on a 32-bit shared parallel bus with active-low handshake lines. A local requester pulses `start` with an address, a four-bit bus command and a beat count. The block then raises its bus request and waits until the arbiter grants the bus while no other master is driving it. It drives one address phase and then runs data phases. Each phase completes only when the target has claimed the cycle and signals ready.

A target that never claims the cycle is caught by a claim watchdog. The block then backs off with a master abort. A target that signals stop ends a burst early as a disconnect. Every control line is modelled as a value and output-enable pair, so the pads can sit outside the block. At the end of every transaction the block drives its frame and initiator-ready lines inactive for one release cycle, and `done` pulses in that cycle. During the pulse a completion code and the number of beats moved are valid.

For writes the local side keeps `wdata` valid for the current beat and advances it after each `data_ack`. For reads it samples `ad_i` in the cycles where `data_ack` is high.

Top module: `pci_init_seq`

## Requirements
- R1: After reset `req_n_o` and `done` are 1 and 0. `busy`, `frame_oe_o`, `irdy_oe_o`, `ad_oe_o` and `cbe_oe_o` are all 0.
- R2: A `start` pulse while idle drives `req_n_o` low from the next cycle on. It stays low until grant (`gnt_n_i`=0) is sampled together with an idle bus (`frame_n_i`=1 and `irdy_n_i`=1). A grant without a pending request, or with a busy bus, starts nothing.
- R3: The cycle after such a grant is the address phase. `frame_n_o` is driven 0, `irdy_n_o` is driven 1, `ad_o` equals the latched address and `cbe_o` equals the latched command, and `req_n_o` is back at 1.
- R4: A data beat completes (`data_ack`=1) only in a cycle where `devsel_n_i` and `trdy_n_i` are both 0. Every other data cycle is a wait state.
- R5: During data phases `irdy_n_o` is driven 0. `frame_n_o` is 0 on every beat except the final one of the requested length, where it is 1. Initiator-ready is never released in a cycle that follows one with frame still asserted.
- R6: After the final beat the next cycle is a release cycle. In it frame and initiator-ready are driven 1, `done`=1, `st_code`=0 (OK) and `st_beats` equals the length. In the cycle after that, every output enable is 0.
- R7: If `devsel_n_i` is not sampled 0 on any of the first 5 data-phase edges, the block ends with a master abort. It drives one cycle with frame at 1 and initiator-ready at 0, then the release cycle, with `st_code`=2 and `st_beats`=0. A claim on the 5th edge is still accepted.
- R8: A stop from the claiming target (`stop_n_i`=0) ends the transaction. A beat completing on the same edge is counted. The code is 1 (DISCONNECT) unless that edge completed the final beat, in which case it is 0. The release follows as in R7.
- R9: A command with bit 0 set is a write, and `ad_o` then carries `wdata` with `ad_oe_o`=1 on every beat. For a read `ad_oe_o` is 0 on every beat. The byte enables (`cbe_o`) are all 0 during data phases.
- R10: A requested length of 0 is treated as a single beat.
- R11: A `start` pulse while a transaction is in progress is ignored, and the status reports the original transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction with the values below (idle only) |
| addr | input | 32 | Transaction address |
| cmd | input | 4 | Bus command, bit 0 set means write |
| len | input | 4 | Number of data beats (0 counts as 1) |
| wdata | input | 32 | Write data for the current beat |
| gnt_n_i | input | 1 | Arbiter grant, active low |
| frame_n_i | input | 1 | Bus frame line as seen on the bus |
| irdy_n_i | input | 1 | Bus initiator-ready line as seen on the bus |
| devsel_n_i | input | 1 | Target claim, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop request, active low |
| ad_i | input | 32 | Address/data bus input (read data) |
| req_n_o | output | 1 | Bus request, active low |
| frame_n_o | output | 1 | Frame value |
| frame_oe_o | output | 1 | Frame output enable |
| irdy_n_o | output | 1 | Initiator-ready value |
| irdy_oe_o | output | 1 | Initiator-ready output enable |
| ad_o | output | 32 | Address/data output |
| ad_oe_o | output | 1 | Address/data output enable |
| cbe_o | output | 4 | Command / byte-enable output |
| cbe_oe_o | output | 1 | Command / byte-enable output enable |
| data_ack | output | 1 | A beat completes at the coming edge |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| st_code | output | 2 | 0 OK, 1 DISCONNECT, 2 MASTER_ABORT (valid with done) |
| st_beats | output | 4 | Beats transferred (valid with done) |

## Verification
A behavioural target answers each transaction with a chosen claim latency, number of ready wait states and stop position, and the arbiter grant is delayed by a chosen number of cycles. Random mixes of these settings, drawn from a fixed seed, are combined with directed cases. The claim latencies 4 and 5 separate a late claim from a master abort. A stop on a middle beat and a stop on the final beat separate DISCONNECT from OK. Reads against writes show whether the data bus is driven, a zero length shows the one-beat rule, and a grant given while another master holds frame, or given with no request pending, shows that the block does not start early.

// File: rtl/pis_pkg.sv
package pis_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_REQ, S_ADDR, S_DATA, S_END, S_REL
   } pis_state_t;

   typedef enum logic [1:0] {
      ST_OK   = 2'd0,
      ST_DISC = 2'd1,
      ST_MABT = 2'd2
   } pis_code_t;
endpackage

// File: rtl/pis_claim_timer.sv
module pis_claim_timer #(
   parameter int TMO = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic claim_i,
   output logic claimed,
   output logic expire
);
   localparam int CW = (TMO < 2) ? 1 : $clog2(TMO);
   localparam logic [CW-1:0] LAST = CW'(TMO - 1);

   if (TMO < 1) begin : g_bad_tmo
      $error("pis_claim_timer: TMO must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          claimed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         claimed_q <= 1'b0;
      end else if (clr) begin
         cnt       <= '0;
         claimed_q <= 1'b0;
      end else if (run) begin
         if (claim_i)
            claimed_q <= 1'b1;
         else if (!claimed_q && cnt != LAST)
            cnt <= cnt + 1'b1;
      end
   end

   assign claimed = claimed_q | claim_i;
   assign expire  = run & ~claimed & (cnt == LAST);

   AST_EXPIRE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !run); // R7
endmodule

// File: rtl/pis_beat_ctr.sv
module pis_beat_ctr #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-1:0] cnt,
   output logic             last
);
   if (LEN_W < 1) begin : g_bad_len
      $error("pis_beat_ctr: LEN_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + 1'b1;
   end

   assign last = ({1'b0, cnt} + 1'b1) == {1'b0, len_i};

   AST_BEAT_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (cnt < len_i)); // R8
endmodule

// File: rtl/pci_init_seq.sv
module pci_init_seq
   import pis_pkg::*;
#(
   parameter int AD_W  = 32,
   parameter int CBE_W = 4,
   parameter int LEN_W = 4,
   parameter int TMO   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AD_W-1:0]  addr,
   input  logic [CBE_W-1:0] cmd,
   input  logic [LEN_W-1:0] len,
   input  logic [AD_W-1:0]  wdata,
   input  logic             gnt_n_i,
   input  logic             frame_n_i,
   input  logic             irdy_n_i,
   input  logic             devsel_n_i,
   input  logic             trdy_n_i,
   input  logic             stop_n_i,
   input  logic [AD_W-1:0]  ad_i,
   output logic             req_n_o,
   output logic             frame_n_o,
   output logic             frame_oe_o,
   output logic             irdy_n_o,
   output logic             irdy_oe_o,
   output logic [AD_W-1:0]  ad_o,
   output logic             ad_oe_o,
   output logic [CBE_W-1:0] cbe_o,
   output logic             cbe_oe_o,
   output logic             data_ack,
   output logic             busy,
   output logic             done,
   output logic [1:0]       st_code,
   output logic [LEN_W-1:0] st_beats
);
   localparam logic [CBE_W-1:0] BE_ALL = '0;
   localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);

   if (AD_W < 8) begin : g_bad_ad
      $error("pci_init_seq: AD_W too small");
   end
   if (CBE_W < 1) begin : g_bad_cbe
      $error("pci_init_seq: CBE_W must be at least 1");
   end

   pis_state_t       state, state_nx;
   logic [AD_W-1:0]  addr_q;
   logic [CBE_W-1:0] cmd_q;
   logic [LEN_W-1:0] len_q;
   pis_code_t        code_q, code_nx;
   logic             claimed, expire, last, xfer, stop_seen;
   logic             in_data, is_wr;
   logic [AD_W-1:0]  rd_unused;

   assign rd_unused = ad_i;  // read data is sampled by the local side at data_ack
   assign in_data   = (state == S_DATA);
   assign is_wr     = cmd_q[0];
   assign xfer      = in_data & claimed & ~trdy_n_i;
   assign stop_seen = in_data & claimed & ~stop_n_i;

   pis_claim_timer #(.TMO(TMO)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(state == S_ADDR), .run(in_data),
      .claim_i(~devsel_n_i), .claimed(claimed), .expire(expire));

   pis_beat_ctr #(.LEN_W(LEN_W)) u_beats (
      .clk(clk), .rst_n(rst_n), .clr(state == S_ADDR), .inc(xfer),
      .len_i(len_q), .cnt(st_beats), .last(last));

   always_comb begin
      state_nx = state;
      code_nx  = code_q;
      unique case (state)
         S_IDLE: if (start) state_nx = S_REQ;
         S_REQ:  if (!gnt_n_i && frame_n_i && irdy_n_i) state_nx = S_ADDR;
         S_ADDR: state_nx = S_DATA;
         S_DATA: begin
            if (expire) begin
               state_nx = S_END;
               code_nx  = ST_MABT;
            end else if (xfer && last) begin
               state_nx = S_REL;
               code_nx  = ST_OK;
            end else if (stop_seen) begin
               state_nx = S_END;
               code_nx  = ST_DISC;
            end
         end
         S_END:  state_nx = S_REL;
         S_REL:  state_nx = S_IDLE;
         default: state_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         code_q <= ST_OK;
         addr_q <= '0;
         cmd_q  <= '0;
         len_q  <= ONE;
      end else begin
         state  <= state_nx;
         code_q <= code_nx;
         if (state == S_IDLE && start) begin
            addr_q <= addr;
            cmd_q  <= cmd;
            len_q  <= (len == '0) ? ONE : len;
         end
      end
   end

   // bus-side drive, decoded from the registered state
   always_comb begin
      req_n_o    = (state != S_REQ);
      frame_oe_o = state inside {S_ADDR, S_DATA, S_END, S_REL};
      irdy_oe_o  = frame_oe_o;
      frame_n_o  = !((state == S_ADDR) || (in_data && !last));
      irdy_n_o   = !(in_data || state == S_END);
      ad_oe_o    = (state == S_ADDR) || (in_data && is_wr);
      ad_o       = (state == S_ADDR) ? addr_q : wdata;
      cbe_oe_o   = (state == S_ADDR) || in_data;
      cbe_o      = (state == S_ADDR) ? cmd_q : BE_ALL;
   end

   assign data_ack = xfer;
   assign busy     = (state != S_IDLE);
   assign done     = (state == S_REL);
   assign st_code  = code_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_ABORT_NO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && st_code == ST_MABT) |-> (st_beats == '0)); // R7
   AST_ADDR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_oe_o && !frame_n_o && irdy_oe_o && irdy_n_o)
         |-> $past(!gnt_n_i && frame_n_i && irdy_n_i)); // R3
   AST_IRDY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (irdy_oe_o && irdy_n_o && $past(irdy_oe_o && !irdy_n_o))
         |-> $past(frame_n_o)); // R5
endmodule

// File: tb/pci_init_seq_bench.sv
`timescale 1ns/1ps
module pci_init_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] addr = '0;
   logic [3:0]  cmd = '0;
   logic [3:0]  len = '0;
   logic [31:0] wdata = '0;
   logic        gnt_n = 1'b1, frame_n_i = 1'b1, irdy_n_i = 1'b1;
   logic        devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
   logic [31:0] ad_i = '0;
   logic        req_n, frame_n_o, frame_oe, irdy_n_o, irdy_oe, ad_oe, cbe_oe;
   logic [31:0] ad_o;
   logic [3:0]  cbe_o;
   logic        data_ack, busy, done;
   logic [1:0]  st_code;
   logic [3:0]  st_beats;

   int checks = 0, errors = 0;
   // target / arbiter configuration
   int t_dlat = 0, t_ws = 0, t_stop = 0, g_delay = 0;
   int d, w, tb, gcnt = 0, ack_idx = 0, len_eff = 1;
   bit t_done = 0, is_wr = 0, last_fhil = 0, cur_fhil = 0;
   logic [31:0] exp_addr = '0;
   logic [3:0]  exp_cmd = '0;

   always #4 clk = ~clk;

   pci_init_seq u_pci_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .cmd(cmd), .len(len),
      .wdata(wdata), .gnt_n_i(gnt_n), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
      .devsel_n_i(devsel_n), .trdy_n_i(trdy_n), .stop_n_i(stop_n), .ad_i(ad_i),
      .req_n_o(req_n), .frame_n_o(frame_n_o), .frame_oe_o(frame_oe),
      .irdy_n_o(irdy_n_o), .irdy_oe_o(irdy_oe), .ad_o(ad_o), .ad_oe_o(ad_oe),
      .cbe_o(cbe_o), .cbe_oe_o(cbe_oe), .data_ack(data_ack), .busy(busy),
      .done(done), .st_code(st_code), .st_beats(st_beats));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_code(input int l, input int dl, input int sa);
      if (dl >= 5) return 2;
      if (sa != 0 && sa < l) return 1;
      return 0;
   endfunction

   function automatic int exp_beats(input int l, input int dl, input int sa);
      if (dl >= 5) return 0;
      if (sa != 0 && sa < l) return sa;
      return l;
   endfunction

   // arbiter, behavioural target and per-cycle monitor
   always begin
      @(negedge clk);
      last_fhil = cur_fhil;
      cur_fhil  = frame_oe && frame_n_o && irdy_oe && !irdy_n_o;
      if (!req_n) gcnt++; else gcnt = 0;
      gnt_n = (g_delay == 0) ? 1'b0 : !(!req_n && gcnt > g_delay);
      if (frame_oe && !frame_n_o && irdy_oe && irdy_n_o) begin
         d = 0; w = 0; tb = 0; t_done = 0; ack_idx = 0;
         devsel_n = 1; trdy_n = 1; stop_n = 1;
         chk("R3 addr", ad_o, exp_addr);
         chk("R3 cmd", {28'd0, cbe_o}, {28'd0, exp_cmd});
         chk("R3 oe/req", {29'd0, ad_oe, cbe_oe, req_n}, 32'd7);
      end else if (irdy_oe && !irdy_n_o && !t_done) begin
         d++;
         if (d > t_dlat) begin
            devsel_n = 0;
            stop_n   = 1;
            if (w == t_ws) begin
               trdy_n = 0; tb++; w = 0;
               if (tb == t_stop) begin stop_n = 0; t_done = 1; end
            end else begin
               trdy_n = 1; w++;
            end
         end else begin
            devsel_n = 1; trdy_n = 1; stop_n = 1;
         end
      end else begin
         devsel_n = 1; trdy_n = 1; stop_n = 1;
      end
      wdata = 32'hC0DE_0000 + ack_idx;
      #1;
      if (trdy_n && data_ack) chk("R4 ack without trdy", 32'd1, 32'd0);
      if (data_ack) begin
         chk("R5 frame on beat", {31'd0, frame_n_o}, {31'd0, ack_idx == len_eff - 1});
         chk("R9 byte enables", {28'd0, cbe_o}, 32'd0);
         if (is_wr) chk("R9 write data", ad_oe ? ad_o : 32'hDEAD, wdata);
         else       chk("R9 read no drive", {31'd0, ad_oe}, 32'd0);
         ack_idx++;
      end
   end

   task automatic run_txn(input int l, input logic [3:0] c, input int dl, input int ws,
                          input int sa, input int gd, input bit extra_start);
      int el, ec, eb;
      bit seen;
      el = (l == 0) ? 1 : l;
      ec = exp_code(el, dl, sa);
      eb = exp_beats(el, dl, sa);
      @(negedge clk);
      t_dlat = dl; t_ws = ws; t_stop = sa; g_delay = gd;
      len_eff = el; is_wr = c[0];
      exp_addr = 32'h4000_0000 + 32'(l * 16 + dl); exp_cmd = c;
      addr = exp_addr; cmd = c; len = 4'(l); start = 1;
      @(negedge clk);
      start = 0; addr = 32'hFFFF_0000; len = 4'd9;
      if (extra_start) begin
         repeat (3) @(negedge clk);
         start = 1; len = 4'd7;
         @(negedge clk);
         start = 0;
      end
      seen = 0;
      for (int i = 0; i < 300 && !seen; i++) begin
         @(negedge clk); #2;
         if (done) seen = 1;
      end
      chk("R6 done seen", {31'd0, seen}, 32'd1);
      if (seen) begin
         chk(extra_start ? "R11 code" : (ec == 2 ? "R7 code" : (ec == 1 ? "R8 code" : "R6 code")),
             {30'd0, st_code}, 32'(ec));
         chk(extra_start ? "R11 beats" : (el != l ? "R10 beats" : "R8 beats"),
             {28'd0, st_beats}, 32'(eb));
         chk("R4 ack count", 32'(ack_idx), 32'(eb));
         chk("R6 release drive", {28'd0, frame_oe, frame_n_o, irdy_oe, irdy_n_o}, 32'hF);
         chk("R7 frame high irdy low before release", {31'd0, last_fhil}, 32'd1);
         @(negedge clk); #2;
         chk("R6 idle after release", {28'd0, frame_oe, irdy_oe, ad_oe, busy}, 32'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #2;
      chk("R1 req_n", {31'd0, req_n}, 32'd1);
      chk("R1 enables", {28'd0, frame_oe, irdy_oe, ad_oe, cbe_oe}, 32'd0);
      chk("R1 busy/done", {30'd0, busy, done}, 32'd0);
      // R2: parked grant, nothing pending
      repeat (5) @(negedge clk);
      #2;
      chk("R2 idle grant req_n", {31'd0, req_n}, 32'd1);
      chk("R2 idle grant frame", {31'd0, frame_oe}, 32'd0);
      // R2: grant while another master holds frame
      @(negedge clk);
      frame_n_i = 0; exp_addr = 32'h1234_5678; exp_cmd = 4'h7;
      len_eff = 1; is_wr = 1; t_dlat = 0; t_ws = 0; t_stop = 0;
      addr = exp_addr; cmd = 4'h7; len = 4'd1; start = 1;
      @(negedge clk); start = 0;
      repeat (3) @(negedge clk);
      #2;
      chk("R2 busy bus holds request", {31'd0, req_n}, 32'd0);
      chk("R2 busy bus no frame", {31'd0, frame_oe}, 32'd0);
      frame_n_i = 1;
      repeat (8) @(negedge clk);
      #2;
      chk("R2 finished after bus idle", {31'd0, busy}, 32'd0);
      // directed corners
      run_txn(1, 4'h7, 0, 0, 0, 0, 0);   // R6 single write
      run_txn(4, 4'h6, 0, 2, 0, 2, 0);   // R4 read burst with waits
      run_txn(2, 4'h7, 4, 0, 0, 0, 0);   // R7 claim on 5th edge accepted
      run_txn(3, 4'h6, 5, 0, 0, 0, 0);   // R7 master abort
      run_txn(1, 4'h7, 99, 0, 0, 1, 0);  // R7 never claimed
      run_txn(5, 4'h7, 1, 1, 2, 0, 0);   // R8 disconnect mid burst
      run_txn(3, 4'h6, 0, 0, 3, 0, 0);   // R8 stop on final beat -> OK
      run_txn(0, 4'h7, 0, 0, 0, 0, 0);   // R10 zero length
      run_txn(4, 4'h7, 0, 1, 0, 0, 1);   // R11 start while busy
      // constrained random
      void'($urandom(32'd2024));
      for (int k = 0; k < 40; k++) begin
         int rl, rd, rw, rs, rg;
         rl = $urandom_range(1, 6);
         rd = $urandom_range(0, 6);
         if (rd == 6) rd = 99;
         rw = $urandom_range(0, 2);
         rs = $urandom_range(0, rl + 1);
         rg = $urandom_range(0, 3);
         run_txn(rl, ($urandom_range(0, 1) == 1) ? 4'h7 : 4'h6, rd, rw, rs, rg, 0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule